// File: doc/BRIEF.md
# Six-Stage Pipeline Occupancy Controller

This block tracks which instructions occupy a six-stage in-order pipeline and moves them forward together, one stage per clock. The stages, in order, are instruction fetch, decode, operand address calculation, operand fetch, execute and operand write-back. Each stage holds a valid bit and a tag, and the tag is the address the instruction was fetched from. The fetch stage presents that address to an external instruction source. In the same cycle the source returns four things: whether the instruction is a conditional branch, whether the branch is taken, the branch target, and whether the operand sits in a register. The block carries these facts down the pipe with the instruction.

A hold input freezes every stage and the fetch pointer. A taken branch resolves as it leaves the execute stage. At that edge the four instructions fetched behind it are discarded and fetch is redirected to the target. This leaves a four-cycle gap in which nothing completes. Every instruction that leaves the write-back stage raises a one-cycle completion strobe carrying its tag. No data is computed: the block models occupancy and control flow only.

Top module: `pipe6_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), no stage holds an instruction and `fetch_valid`, `squash`, `opnd_mem_rd` and `retire_valid` are all 0. In the first cycle after reset is released (one edge with `rst` low), `fetch_valid` is 1 and `fetch_addr` equals the parameter `RESET_PC`.
- R2: With no redirect, the fetch address rises by exactly one on every clock edge where `hold` is low.
- R3: With `hold` low, an instruction fetched in cycle n retires in cycle n+5. The first instruction after reset therefore retires after six idle cycles, counted from the cycle in which reset is released. While the pipe runs undisturbed, one instruction retires per cycle.
- R4: While `hold` is high, `retire_valid` is 0, and at the next edge no stage, no tag and `fetch_addr` change. No instruction is lost or repeated across a hold.
- R5: `squash` is 1 in a cycle where `hold` is low and the execute stage holds a valid branch reported as taken. From the next cycle on, `fetch_addr` equals that branch's target.
- R6: A taken branch retires in the cycle after it resolves. The instructions fetched behind it never retire, including any taken branch among them. Exactly four advancing cycles without a retirement separate the branch from its target's retirement.
- R7: A branch reported as not taken changes neither the fetch sequence nor the retire timing.
- R8: `opnd_mem_rd` is 1 exactly when the operand-fetch stage holds a valid instruction whose operand was reported as not in a register (`ins_reg_opnd` = 0).
- R9: `retire_tag` equals the address from which the retiring instruction was fetched. Instructions retire in program order, meaning the sequential order with taken branches followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes the whole pipe while high |
| fetch_valid | output | 1 | Fetch stage holds an instruction |
| fetch_addr | output | TAG_W | Address being fetched (becomes the tag) |
| ins_branch | input | 1 | Fetched instruction is a conditional branch |
| ins_taken | input | 1 | Branch outcome: taken |
| ins_target | input | TAG_W | Branch target address |
| ins_reg_opnd | input | 1 | Operand is in a register (no memory fetch) |
| squash | output | 1 | Taken branch resolving this cycle |
| opnd_mem_rd | output | 1 | Operand-fetch stage needs a memory read |
| retire_valid | output | 1 | An instruction completes this cycle |
| retire_tag | output | TAG_W | Tag of the completing instruction |

## Verification
The assertions assume that the instruction source answers `fetch_addr` within the same cycle and keeps its answer steady while the address is steady. They also assume that `hold` changes only between edges. The bench meets both conditions with a small program array indexed by the low bits of `fetch_addr`, and it drives `hold` one time step after each rising edge. The programs are chosen so that every fetched address, including the addresses fetched ahead of a squash, falls inside that array.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;

    localparam int unsigned TAG_W   = 12;
    localparam int unsigned N_STAGE = 6;

    typedef enum logic [2:0] {
        ST_FI = 3'd0,
        ST_DI = 3'd1,
        ST_CO = 3'd2,
        ST_FO = 3'd3,
        ST_EX = 3'd4,
        ST_WO = 3'd5
    } stage_e;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic br;
        logic taken;
        logic reg_opnd;
        tag_t target;
    } decode_t;

    typedef struct packed {
        logic    valid;
        tag_t    tag;
        decode_t info;
    } slot_t;

    function automatic logic resolves_taken(slot_t s);
        return s.valid & s.info.br & s.info.taken;
    endfunction

endpackage

// File: rtl/pipe6_fetch.sv
module pipe6_fetch
    import pipe6_pkg::*;
#(
    parameter tag_t RESET_PC = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic redirect,
    input  tag_t target,
    output logic f_valid,
    output tag_t f_tag
);

    tag_t nxt_q;
    tag_t pick;
    logic vld_q;
    tag_t tag_q;

    assign pick = redirect ? target : nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q <= RESET_PC;
            vld_q <= 1'b0;
            tag_q <= '0;
        end else if (advance) begin
            vld_q <= 1'b1;
            tag_q <= pick;
            nxt_q <= pick + 1'b1;
        end
    end

    assign f_valid = vld_q;
    assign f_tag   = tag_q;

    // R2: sequential fetch steps by one
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (advance && !redirect && vld_q) |=> (tag_q == $past(tag_q) + 1'b1));

    // R4: fetch pointer frozen by hold
    a_r4_fetch_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(tag_q) && $stable(vld_q)));

    // R5: redirect lands on the branch target
    a_r5_redirect_target: assert property (@(posedge clk) disable iff (rst)
        (advance && redirect) |=> (vld_q && tag_q == $past(target)));

endmodule

// File: rtl/pipe6_stages.sv
module pipe6_stages
    import pipe6_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  slot_t in_slot,
    output logic  squash,
    output tag_t  redirect_target,
    output logic  fo_mem_rd,
    output logic  wo_valid,
    output tag_t  wo_tag
);

    slot_t [N_STAGE-1:0] chain;

    assign chain[0] = in_slot;
    assign squash   = advance & resolves_taken(chain[ST_EX]);

    for (genvar i = 1; i < N_STAGE; i++) begin : g_stage
        slot_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (advance) begin
                if (squash && (i < int'(ST_WO))) begin
                    q <= '0;
                end else begin
                    q <= chain[i-1];
                end
            end
        end
        assign chain[i] = q;
    end

    assign redirect_target = chain[ST_EX].info.target;
    assign fo_mem_rd       = chain[ST_FO].valid & ~chain[ST_FO].info.reg_opnd;
    assign wo_valid        = chain[ST_WO].valid;
    assign wo_tag          = chain[ST_WO].tag;

    // R4: all stage contents frozen while held
    a_r4_chain_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(chain));

    // R6: younger stages empty after a squash
    a_r6_young_cleared: assert property (@(posedge clk) disable iff (rst)
        squash |=> ({chain[ST_DI].valid, chain[ST_CO].valid,
                     chain[ST_FO].valid, chain[ST_EX].valid} == 4'b0000));

    // R6: the resolving branch itself moves on to write-back
    a_r6_branch_survives: assert property (@(posedge clk) disable iff (rst)
        squash |=> (chain[ST_WO].valid && chain[ST_WO].info.br && chain[ST_WO].info.taken));

endmodule

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl
    import pipe6_pkg::*;
#(
    parameter tag_t RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic             fetch_valid,
    output logic [TAG_W-1:0] fetch_addr,
    input  logic             ins_branch,
    input  logic             ins_taken,
    input  logic [TAG_W-1:0] ins_target,
    input  logic             ins_reg_opnd,
    output logic             squash,
    output logic             opnd_mem_rd,
    output logic             retire_valid,
    output logic [TAG_W-1:0] retire_tag
);

    logic  advance;
    logic  f_valid;
    tag_t  f_tag;
    tag_t  redir_tgt;
    logic  wo_valid;
    tag_t  wo_tag;
    slot_t in_slot;

    assign advance = ~hold;

    pipe6_fetch #(.RESET_PC(RESET_PC)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .redirect (squash),
        .target   (redir_tgt),
        .f_valid  (f_valid),
        .f_tag    (f_tag)
    );

    assign in_slot = '{
        valid: f_valid,
        tag:   f_tag,
        info:  '{br: ins_branch, taken: ins_taken,
                 reg_opnd: ins_reg_opnd, target: ins_target}
    };

    pipe6_stages u_stages (
        .clk             (clk),
        .rst             (rst),
        .advance         (advance),
        .in_slot         (in_slot),
        .squash          (squash),
        .redirect_target (redir_tgt),
        .fo_mem_rd       (opnd_mem_rd),
        .wo_valid        (wo_valid),
        .wo_tag          (wo_tag)
    );

    assign fetch_valid  = f_valid;
    assign fetch_addr   = f_tag;
    assign retire_valid = wo_valid & advance;
    assign retire_tag   = wo_tag;

    // R5: squash and the retirement it precedes stay consistent
    a_r5_squash_then_retire: assert property (@(posedge clk) disable iff (rst)
        squash |=> wo_valid);

endmodule

// File: tb/sim_pipe6_ctrl.sv
module sim_pipe6_ctrl;
    import pipe6_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold = 1'b0;
    logic fetch_valid, squash, opnd_mem_rd, retire_valid;
    logic [TAG_W-1:0] fetch_addr, retire_tag;
    logic ins_branch, ins_taken, ins_reg_opnd;
    logic [TAG_W-1:0] ins_target;

    always #2 clk = ~clk;

    bit   prog_br [64];
    bit   prog_tk [64];
    bit   prog_rg [64];
    tag_t prog_tg [64];

    assign ins_branch   = prog_br[fetch_addr[5:0]];
    assign ins_taken    = prog_tk[fetch_addr[5:0]];
    assign ins_reg_opnd = prog_rg[fetch_addr[5:0]];
    assign ins_target   = prog_tg[fetch_addr[5:0]];

    pipe6_ctrl u0 (
        .clk(clk), .rst(rst), .hold(hold),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .ins_branch(ins_branch), .ins_taken(ins_taken),
        .ins_target(ins_target), .ins_reg_opnd(ins_reg_opnd),
        .squash(squash), .opnd_mem_rd(opnd_mem_rd),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    typedef struct { tag_t tag; int gap; } exp_t;
    exp_t q[$];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            prog_br[i] = 0; prog_tk[i] = 0; prog_rg[i] = 0; prog_tg[i] = '0;
        end
    endtask

    // driver side: expected retire stream in program order
    task automatic push_path(int n);
        tag_t pc = '0;
        int gap = 6;
        for (int k = 0; k < n; k++) begin
            q.push_back('{pc, gap});
            if (prog_br[pc[5:0]] && prog_tk[pc[5:0]]) begin
                gap = 4;
                pc  = prog_tg[pc[5:0]];
            end else begin
                gap = 0;
                pc  = pc + 1'b1;
            end
        end
    endtask

    // monitor
    int   idle = 0;
    bit   prev_hold = 0;
    tag_t prev_addr = '0;
    bit   prev_squash = 0;
    bit   pend = 0;
    tag_t pend_addr = '0;
    bit   last_nt = 0;
    exp_t e;

    always @(negedge clk) begin
        if (rst) begin
            idle = 0; prev_hold = 0; prev_squash = 0; pend = 0; last_nt = 0;
        end else begin
            if (prev_hold)
                check(fetch_addr == prev_addr, "R4", "fetch_addr moved during hold",
                      int'(fetch_addr), int'(prev_addr));
            if (hold)
                check(!retire_valid, "R4", "retire while held", int'(retire_valid), 0);
            if (prev_squash) begin
                pend = 1;
                pend_addr = fetch_addr;
            end
            if (retire_valid) begin
                if (pend) begin
                    check(prog_br[retire_tag[5:0]] && prog_tk[retire_tag[5:0]], "R5",
                          "squash without taken branch", int'(retire_tag), -1);
                    check(pend_addr == prog_tg[retire_tag[5:0]], "R5",
                          "redirect address", int'(pend_addr), int'(prog_tg[retire_tag[5:0]]));
                    pend = 0;
                end
                if (q.size() > 0) begin
                    e = q.pop_front();
                    check(retire_tag == e.tag, "R9", "retire tag order",
                          int'(retire_tag), int'(e.tag));
                    if (e.gap == 6)
                        check(idle == e.gap, "R3", "fill latency", idle, e.gap);
                    else if (e.gap == 4)
                        check(idle == e.gap, "R6", "branch penalty", idle, e.gap);
                    else if (last_nt)
                        check(idle == e.gap, "R7", "not-taken branch gap", idle, e.gap);
                    else
                        check(idle == e.gap, "R3", "one per cycle", idle, e.gap);
                    last_nt = prog_br[retire_tag[5:0]] && !prog_tk[retire_tag[5:0]];
                end
                idle = 0;
            end else if (!hold) begin
                idle++;
            end
            prev_hold   = hold;
            prev_addr   = fetch_addr;
            prev_squash = squash;
        end
    end

    task automatic run_phase(int n, bit use_hold, bit fo_check);
        int cyc;
        rst = 1; hold = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!fetch_valid && !retire_valid && !squash && !opnd_mem_rd, "R1",
              "outputs during reset",
              int'({fetch_valid, retire_valid, squash, opnd_mem_rd}), 0);
        q.delete();
        push_path(n);
        @(posedge clk);
        #1 rst = 0;
        cyc = 0;
        while (q.size() > 0 && cyc < 2000) begin
            @(negedge clk);
            if (cyc == 1)
                check(fetch_valid && fetch_addr == '0, "R1", "first fetch address",
                      int'(fetch_addr), 0);
            if (fo_check && cyc <= 12) begin
                bit exp_rd;
                exp_rd = (cyc >= 4) ? !prog_rg[cyc-4] : 1'b0;
                check(opnd_mem_rd == exp_rd, "R8", "operand memory read",
                      int'(opnd_mem_rd), int'(exp_rd));
            end
            if (fo_check && cyc >= 2 && cyc <= 12)
                check(fetch_addr == tag_t'(cyc - 1), "R2", "sequential fetch",
                      int'(fetch_addr), cyc - 1);
            @(posedge clk);
            #1 hold = use_hold ? ($urandom_range(0, 2) == 0) : 1'b0;
            cyc++;
        end
        check(q.size() == 0, "R9", "retire stream incomplete", q.size(), 0);
        hold = 0;
    endtask

    initial begin
        clear_prog();
        prog_rg[2] = 1; prog_rg[4] = 1; prog_rg[9] = 1;
        run_phase(20, 0, 1);

        clear_prog();
        prog_br[3] = 1;                                  // not taken
        prog_br[7] = 1; prog_tk[7] = 1; prog_tg[7] = 30;
        prog_br[8] = 1; prog_tk[8] = 1; prog_tg[8] = 50; // fetched behind 7, must die
        prog_br[30] = 1; prog_tk[30] = 1; prog_tg[30] = 35;
        prog_br[38] = 1;                                 // not taken
        run_phase(25, 0, 0);

        run_phase(25, 1, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule